// File: doc/BRIEF.md
# Escaped Message Framer with Checksum

This block turns a raw serial byte channel into whole messages and back. Two kinds of message travel on the channel: data messages, which carry a sequence byte, a function group, a command and data, and control messages, which carry short link notices such as a protocol version, a capabilities report, a reset notice or an interrupt enable request. A data message is closed by the byte 0xA0 and a control message by 0xA1. Any content byte that collides with a framing byte is sent as the escape byte 0xAA followed by the same byte with bit 4 set.

On the receive side the block removes escapes and collects each message in a local buffer. It verifies a data message by its zero-sum checksum and passes on only messages that are valid. The checksum and the terminator are never passed on. On the transmit side it accepts payload beats with a last flag and a control flag. It escapes special bytes, adds the checksum to data messages and emits the terminator that matches the message type. Both sides use valid/ready handshakes. Receive faults are reported by a one-cycle error pulse that carries a cause code.

Top module: `escaped_msg_framer`

## Requirements
- R1: A received message is closed by 0xA0 (data) or 0xA1 (control). Its payload is emitted with `rxm_last` high on the final payload byte only and with `rxm_ctrl` = 1 for a control message and 0 for a data message. Terminator bytes are never emitted.
- R2: On receive, 0xAA followed by a byte with bit 4 set yields that byte with bit 4 cleared as one payload byte. This holds for any value, not only the framing bytes.
- R3: Before 0xA0, all decoded bytes of a data message, the checksum included, must sum to 0 modulo 256. If they do not, the message is dropped and `rx_err` pulses with `rx_err_code` = 1. The last decoded byte (the checksum) is never emitted.
- R4: A data message with fewer than MIN_DATA (default 4) decoded bytes before 0xA0 is dropped with `rx_err_code` = 3. So is a control message with no bytes before 0xA1.
- R5: 0xAA followed by a byte with bit 4 clear gives `rx_err_code` = 0. If that byte is 0xA0 or 0xA1, it still closes the frame and the next byte starts a new message. Otherwise the receiver discards until the next terminator.
- R6: A message with more than MAX_LEN (default 64) decoded bytes gives `rx_err_code` = 2 when the extra byte arrives, and the receiver discards until the next terminator. Exactly MAX_LEN bytes is accepted.
- R7: After any receive error, no byte up to and including the closing terminator is emitted, and the next message is received intact.
- R8: On transmit, every payload or checksum byte equal to 0xA0, 0xA1 or 0xAA is sent as 0xAA followed by the byte with bit 4 set. All other bytes are sent unchanged.
- R9: On transmit, a data message (`txm_ctrl` = 0 on the last beat) is followed by a checksum byte equal to the two's complement of the payload sum, then 0xA0. A control message is followed directly by 0xA1.
- R10: `rxm_valid`/`rxm_data`/`rxm_last` and `txw_valid`/`txw_data` hold steady while their ready is low. The receiver does not accept channel bytes while a message is being emitted.
- R11: After reset, no output is valid, `rx_err` is low and the receiver is ready for channel bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxw_valid | input | 1 | Channel byte offered to the receiver |
| rxw_ready | output | 1 | Receiver accepts the channel byte |
| rxw_data | input | 8 | Channel byte in |
| rxm_valid | output | 1 | Decoded payload byte valid |
| rxm_ready | input | 1 | Consumer takes the payload byte |
| rxm_data | output | 8 | Decoded payload byte |
| rxm_last | output | 1 | Final payload byte of the message |
| rxm_ctrl | output | 1 | 1 for a control message, 0 for data |
| rx_err | output | 1 | One-cycle receive error pulse |
| rx_err_code | output | 2 | Cause: 0 escape, 1 checksum, 2 too long, 3 too short |
| txm_valid | input | 1 | Payload byte to send |
| txm_ready | output | 1 | Transmitter takes the payload byte |
| txm_data | input | 8 | Payload byte |
| txm_last | input | 1 | Final payload byte of the message |
| txm_ctrl | input | 1 | Message type, taken on the last beat |
| txw_valid | output | 1 | Channel byte out valid |
| txw_ready | input | 1 | Channel takes the byte |
| txw_data | output | 8 | Channel byte out |

## Verification
The hardest case to reach is a transmitted checksum that is itself a framing byte, because it forces the escape path after the payload. The table includes a payload (0x10 0x20 0x30) whose checksum is 0xA0, and the captured channel bytes are then looped back into the receiver. A second hard case is an illegal escape whose second byte is a terminator, because that byte must resynchronise the receiver instead of starting a discard. The stimulus sends such a broken frame directly followed by a valid frame and checks that the valid frame arrives. Overflow is reached by streaming MAX_LEN+1 plain bytes, while a table entry with exactly MAX_LEN decoded bytes covers the edge that must be accepted.

// File: rtl/framer_pkg.sv
package framer_pkg;

   localparam logic [7:0] END_DATA  = 8'hA0;
   localparam logic [7:0] END_CTRL  = 8'hA1;
   localparam logic [7:0] ESC_BYTE  = 8'hAA;
   localparam int         MARK_BIT  = 4;
   localparam logic [7:0] MARK_MASK = 8'(1) << MARK_BIT;

   typedef enum logic [1:0] {
      ERR_ESCAPE   = 2'd0,
      ERR_CHECKSUM = 2'd1,
      ERR_OVERLONG = 2'd2,
      ERR_SHORT    = 2'd3
   } err_code_t;

   // classified channel byte
   typedef struct packed {
      logic       term;       // raw byte is a terminator
      logic       term_ctrl;  // terminator closes a control message
      logic       esc_open;   // raw byte opens an escape
      logic       bad_esc;    // byte after escape lacks the marker bit
      logic [7:0] value;      // decoded payload value
   } sym_t;

   function automatic logic needs_escape(input logic [7:0] b);
      return (b == END_DATA) || (b == END_CTRL) || (b == ESC_BYTE);
   endfunction

endpackage

// File: rtl/framer_unescape.sv
module framer_unescape
   import framer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] raw,
   input  logic       take,
   output sym_t       sym
);

   logic esc_pend_q;

   always_comb begin
      sym.term      = (raw == END_DATA) || (raw == END_CTRL);
      sym.term_ctrl = (raw == END_CTRL);
      sym.esc_open  = !esc_pend_q && (raw == ESC_BYTE);
      sym.bad_esc   = esc_pend_q && !raw[MARK_BIT];
      sym.value     = esc_pend_q ? (raw & ~MARK_MASK) : raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         esc_pend_q <= 1'b0;
      else if (take)
         esc_pend_q <= sym.esc_open;
   end

   AST_ESC_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (esc_pend_q && take) |=> !esc_pend_q);   // R2

endmodule

// File: rtl/framer_rx_assemble.sv
module framer_rx_assemble
   import framer_pkg::*;
#(
   parameter int MAX_LEN  = 64,
   parameter int MIN_DATA = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  sym_t       sym,
   input  logic       in_valid,
   output logic       in_ready,
   output logic       m_valid,
   input  logic       m_ready,
   output logic [7:0] m_data,
   output logic       m_last,
   output logic       m_ctrl,
   output logic       err,
   output logic [1:0] err_code
);

   localparam int AW = $clog2(MAX_LEN);
   localparam int CW = $clog2(MAX_LEN + 1);
   localparam logic [CW-1:0] LEN_LIM = CW'(MAX_LEN);
   localparam logic [CW-1:0] LEN_MIN = CW'(MIN_DATA);

   generate
      if (MAX_LEN < 4 || MAX_LEN > 256) begin : g_bad_len
         $error("MAX_LEN must lie in 4..256");
      end
      if (MIN_DATA < 2 || MIN_DATA > MAX_LEN) begin : g_bad_min
         $error("MIN_DATA must lie in 2..MAX_LEN");
      end
   endgenerate

   typedef enum logic [1:0] {ST_COLLECT, ST_DISCARD, ST_PLAY} st_t;

   st_t             st_q, st_d;
   logic [CW-1:0]   cnt_q, cnt_d;
   logic [CW-1:0]   plen_q, plen_d;
   logic [AW-1:0]   rd_q, rd_d;
   logic [7:0]      sum_q, sum_d;
   logic            ctrl_q, ctrl_d;
   logic            wr_en;
   logic            err_d, err_q;
   err_code_t       code_d, code_q;
   logic [7:0]      buf_q [MAX_LEN];
   logic            take;
   logic            at_last;

   assign in_ready = (st_q != ST_PLAY);
   assign take     = in_valid && in_ready;
   assign at_last  = (CW'(rd_q) + CW'(1)) == plen_q;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      sum_d  = sum_q;
      plen_d = plen_q;
      ctrl_d = ctrl_q;
      rd_d   = rd_q;
      wr_en  = 1'b0;
      err_d  = 1'b0;
      code_d = ERR_ESCAPE;
      case (st_q)
         ST_COLLECT: begin
            if (take) begin
               if (sym.bad_esc) begin
                  err_d  = 1'b1;
                  code_d = ERR_ESCAPE;
                  cnt_d  = '0;
                  sum_d  = '0;
                  st_d   = sym.term ? ST_COLLECT : ST_DISCARD;
               end else if (sym.term) begin
                  cnt_d = '0;
                  sum_d = '0;
                  rd_d  = '0;
                  if (sym.term_ctrl) begin
                     if (cnt_q == '0) begin
                        err_d  = 1'b1;
                        code_d = ERR_SHORT;
                     end else begin
                        st_d   = ST_PLAY;
                        plen_d = cnt_q;
                        ctrl_d = 1'b1;
                     end
                  end else if (cnt_q < LEN_MIN) begin
                     err_d  = 1'b1;
                     code_d = ERR_SHORT;
                  end else if (sum_q != 8'h00) begin
                     err_d  = 1'b1;
                     code_d = ERR_CHECKSUM;
                  end else begin
                     st_d   = ST_PLAY;
                     plen_d = cnt_q - CW'(1);
                     ctrl_d = 1'b0;
                  end
               end else if (sym.esc_open) begin
                  st_d = ST_COLLECT;
               end else if (cnt_q == LEN_LIM) begin
                  err_d  = 1'b1;
                  code_d = ERR_OVERLONG;
                  cnt_d  = '0;
                  sum_d  = '0;
                  st_d   = ST_DISCARD;
               end else begin
                  wr_en = 1'b1;
                  cnt_d = cnt_q + CW'(1);
                  sum_d = sum_q + sym.value;
               end
            end
         end
         ST_DISCARD: begin
            if (take && sym.term)
               st_d = ST_COLLECT;
         end
         ST_PLAY: begin
            if (m_ready) begin
               if (at_last) begin
                  st_d = ST_COLLECT;
                  rd_d = '0;
               end else begin
                  rd_d = rd_q + AW'(1);
               end
            end
         end
         default: st_d = ST_COLLECT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_COLLECT;
         cnt_q  <= '0;
         sum_q  <= '0;
         plen_q <= '0;
         ctrl_q <= 1'b0;
         rd_q   <= '0;
         err_q  <= 1'b0;
         code_q <= ERR_ESCAPE;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         sum_q  <= sum_d;
         plen_q <= plen_d;
         ctrl_q <= ctrl_d;
         rd_q   <= rd_d;
         err_q  <= err_d;
         code_q <= code_d;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         buf_q[cnt_q[AW-1:0]] <= sym.value;
   end

   assign m_valid  = (st_q == ST_PLAY);
   assign m_data   = buf_q[rd_q];
   assign m_last   = m_valid && at_last;
   assign m_ctrl   = ctrl_q;
   assign err      = err_q;
   assign err_code = code_q;

   AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));   // R10
   AST_ERR_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !m_valid);   // R7
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LEN_LIM);   // R6
   AST_NO_EMPTY_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (plen_q != '0));   // R4

endmodule

// File: rtl/framer_tx_encode.sv
module framer_tx_encode
   import framer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       m_valid,
   output logic       m_ready,
   input  logic [7:0] m_data,
   input  logic       m_last,
   input  logic       m_ctrl,
   output logic       o_valid,
   input  logic       o_ready,
   output logic [7:0] o_data
);

   typedef enum logic [2:0] {T_IN, T_ESC, T_SUM, T_SUMESC, T_TERM} tst_t;

   tst_t       st_q;
   logic [7:0] hold_q;
   logic [7:0] sum_q;
   logic       last_q;
   logic       ctrl_q;
   logic [7:0] ck;

   assign ck = 8'h00 - sum_q;

   always_comb begin
      o_valid = 1'b1;
      o_data  = 8'h00;
      m_ready = 1'b0;
      case (st_q)
         T_IN: begin
            o_valid = m_valid;
            o_data  = needs_escape(m_data) ? ESC_BYTE : m_data;
            m_ready = o_ready;
         end
         T_ESC:    o_data = hold_q;
         T_SUM:    o_data = needs_escape(ck) ? ESC_BYTE : ck;
         T_SUMESC: o_data = ck | MARK_MASK;
         T_TERM:   o_data = ctrl_q ? END_CTRL : END_DATA;
         default:  o_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= T_IN;
         hold_q <= '0;
         sum_q  <= '0;
         last_q <= 1'b0;
         ctrl_q <= 1'b0;
      end else begin
         case (st_q)
            T_IN: begin
               if (m_valid && o_ready) begin
                  sum_q  <= sum_q + m_data;
                  last_q <= m_last;
                  ctrl_q <= m_ctrl;
                  if (needs_escape(m_data)) begin
                     hold_q <= m_data | MARK_MASK;
                     st_q   <= T_ESC;
                  end else if (m_last) begin
                     st_q <= m_ctrl ? T_TERM : T_SUM;
                  end
               end
            end
            T_ESC: begin
               if (o_ready) begin
                  if (last_q) st_q <= ctrl_q ? T_TERM : T_SUM;
                  else        st_q <= T_IN;
               end
            end
            T_SUM: begin
               if (o_ready) st_q <= needs_escape(ck) ? T_SUMESC : T_TERM;
            end
            T_SUMESC: begin
               if (o_ready) st_q <= T_TERM;
            end
            T_TERM: begin
               if (o_ready) begin
                  st_q  <= T_IN;
                  sum_q <= '0;
               end
            end
            default: st_q <= T_IN;
         endcase
      end
   end

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));   // R10
   AST_TX_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_ready && o_data == ESC_BYTE) |=> (o_valid && o_data[MARK_BIT]));   // R8

endmodule

// File: rtl/escaped_msg_framer.sv
module escaped_msg_framer
   import framer_pkg::*;
#(
   parameter int MAX_LEN  = 64,
   parameter int MIN_DATA = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxw_valid,
   output logic       rxw_ready,
   input  logic [7:0] rxw_data,
   output logic       rxm_valid,
   input  logic       rxm_ready,
   output logic [7:0] rxm_data,
   output logic       rxm_last,
   output logic       rxm_ctrl,
   output logic       rx_err,
   output logic [1:0] rx_err_code,
   input  logic       txm_valid,
   output logic       txm_ready,
   input  logic [7:0] txm_data,
   input  logic       txm_last,
   input  logic       txm_ctrl,
   output logic       txw_valid,
   input  logic       txw_ready,
   output logic [7:0] txw_data
);

   sym_t rx_sym;

   framer_unescape u_unesc (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (rxw_data),
      .take  (rxw_valid && rxw_ready),
      .sym   (rx_sym)
   );

   framer_rx_assemble #(
      .MAX_LEN  (MAX_LEN),
      .MIN_DATA (MIN_DATA)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym      (rx_sym),
      .in_valid (rxw_valid),
      .in_ready (rxw_ready),
      .m_valid  (rxm_valid),
      .m_ready  (rxm_ready),
      .m_data   (rxm_data),
      .m_last   (rxm_last),
      .m_ctrl   (rxm_ctrl),
      .err      (rx_err),
      .err_code (rx_err_code)
   );

   framer_tx_encode u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .m_valid (txm_valid),
      .m_ready (txm_ready),
      .m_data  (txm_data),
      .m_last  (txm_last),
      .m_ctrl  (txm_ctrl),
      .o_valid (txw_valid),
      .o_ready (txw_ready),
      .o_data  (txw_data)
   );

endmodule

// File: tb/escaped_msg_framer_test.sv
module escaped_msg_framer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxw_valid = 1'b0, rxw_ready;
   logic [7:0] rxw_data = 8'h00;
   logic       rxm_valid, rxm_ready = 1'b1, rxm_last, rxm_ctrl;
   logic [7:0] rxm_data;
   logic       rx_err;
   logic [1:0] rx_err_code;
   logic       txm_valid = 1'b0, txm_ready, txm_last = 1'b0, txm_ctrl = 1'b0;
   logic [7:0] txm_data = 8'h00;
   logic       txw_valid, txw_ready = 1'b1;
   logic [7:0] txw_data;

   always #10 clk = ~clk;

   escaped_msg_framer uut (.*);

   int vec_n = 0, bad_n = 0;
   logic [7:0] wcap [512];
   int         wcn = 0;
   logic [7:0] rcap [256];
   logic       rlast [256];
   logic       rctrl [256];
   int         rcn = 0;
   int         errn = 0;
   logic [1:0] lastcode = 2'd0;
   logic [7:0] exp_w [512];
   int         exp_n;
   logic [7:0] pay [128];
   logic [7:0] raw [128];

   always @(posedge clk) begin
      if (rst_n) begin
         if (txw_valid && txw_ready) begin wcap[wcn] = txw_data; wcn++; end
         if (rxm_valid && rxm_ready) begin
            rcap[rcn] = rxm_data; rlast[rcn] = rxm_last; rctrl[rcn] = rxm_ctrl; rcn++;
         end
         if (rx_err) begin errn++; lastcode = rx_err_code; end
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      vec_n++; bad_n++;
      $display("FAIL watchdog expired");
      summary();
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      vec_n++;
      if (!ok) begin
         bad_n++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_rx(input logic [7:0] b);
      @(negedge clk);
      rxw_valid = 1'b1;
      rxw_data  = b;
      do @(posedge clk); while (!rxw_ready);
   endtask

   task automatic rx_idle();
      @(negedge clk);
      rxw_valid = 1'b0;
   endtask

   task automatic send_raw(input int n);
      for (int i = 0; i < n; i++) put_rx(raw[i]);
      rx_idle();
      repeat (20) @(posedge clk);
   endtask

   task automatic send_tx(input logic c, input int len, input logic [7:0] base, input logic [7:0] step);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         txm_valid = 1'b1;
         txm_data  = base + 8'(i) * step;
         txm_last  = (i == len - 1);
         txm_ctrl  = c;
         do @(posedge clk); while (!txm_ready);
      end
      @(negedge clk);
      txm_valid = 1'b0;
   endtask

   function automatic logic special(input logic [7:0] b);
      return b == 8'hA0 || b == 8'hA1 || b == 8'hAA;
   endfunction

   task automatic push_enc(input logic [7:0] b);
      if (special(b)) begin
         exp_w[exp_n] = 8'hAA; exp_n++;
         exp_w[exp_n] = b | 8'h10; exp_n++;
      end else begin
         exp_w[exp_n] = b; exp_n++;
      end
   endtask

   // ctrl, length, first byte, increment
   localparam logic [24:0] VECS [8] = '{
      {1'b0, 8'd3,  8'h10, 8'h10},
      {1'b0, 8'd6,  8'hA0, 8'h01},
      {1'b0, 8'd4,  8'hA8, 8'h01},
      {1'b0, 8'd20, 8'h03, 8'h07},
      {1'b1, 8'd2,  8'hFF, 8'h02},
      {1'b1, 8'd2,  8'h08, 8'h17},
      {1'b1, 8'd1,  8'h04, 8'h00},
      {1'b0, 8'd63, 8'h00, 8'h05}
   };

   initial begin
      logic       c, ok;
      int         len, e0;
      logic [7:0] base, step, s;

      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(rxw_ready && !rxm_valid && !txw_valid && !rx_err, "R11 reset state",
          {rxw_ready, rxm_valid, txw_valid, rx_err}, 4'b1000);

      // table walk: encode, then loop the channel bytes back into the receiver
      for (int v = 0; v < 8; v++) begin
         c = VECS[v][24]; len = int'(VECS[v][23:16]);
         base = VECS[v][15:8]; step = VECS[v][7:0];
         exp_n = 0; s = 8'h00;
         for (int i = 0; i < len; i++) begin
            pay[i] = base + 8'(i) * step;
            s = s + pay[i];
            push_enc(pay[i]);
         end
         if (!c) begin push_enc(8'h00 - s); exp_w[exp_n] = 8'hA0; end
         else    exp_w[exp_n] = 8'hA1;
         exp_n++;
         wcn = 0;
         send_tx(c, len, base, step);
         repeat (8) @(posedge clk);
         ok = (wcn == exp_n);
         for (int i = 0; i < exp_n; i++) if (wcap[i] !== exp_w[i]) ok = 1'b0;
         chk(ok, "R8/R9 encoded channel bytes", wcn, exp_n);
         rcn = 0; e0 = errn;
         for (int i = 0; i < wcn; i++) put_rx(wcap[i]);
         rx_idle();
         repeat (len + 8) @(posedge clk);
         ok = (rcn == len) && (errn == e0);
         for (int i = 0; i < len; i++)
            if (rcap[i] !== pay[i] || rlast[i] !== (i == len - 1) || rctrl[i] !== c) ok = 1'b0;
         chk(ok, "R1/R2 received payload", rcn, len);
      end

      // R2 direct escape decode: 01 AA B0 AA BA 02 B3 A0 -> 01 A0 AA 02
      raw[0]=8'h01; raw[1]=8'hAA; raw[2]=8'hB0; raw[3]=8'hAA; raw[4]=8'hBA;
      raw[5]=8'h02; raw[6]=8'hB3; raw[7]=8'hA0;
      rcn = 0; e0 = errn;
      send_raw(8);
      chk(rcn == 4 && rcap[1] == 8'hA0 && rcap[2] == 8'hAA && rcap[3] == 8'h02 &&
          rlast[3] && !rlast[2] && !rctrl[3] && errn == e0, "R2 escape decode", rcn, 4);

      // R3 bad checksum
      raw[0]=8'h01; raw[1]=8'h02; raw[2]=8'h03; raw[3]=8'h05; raw[4]=8'hA0;
      rcn = 0; e0 = errn;
      send_raw(5);
      chk(rcn == 0 && errn == e0 + 1 && lastcode == 2'd1, "R3 checksum error", lastcode, 1);

      // R4 short data message and empty control message
      raw[0]=8'h01; raw[1]=8'h02; raw[2]=8'hFD; raw[3]=8'hA0;
      rcn = 0; e0 = errn;
      send_raw(4);
      chk(rcn == 0 && errn == e0 + 1 && lastcode == 2'd3, "R4 short data", lastcode, 3);
      raw[0]=8'hA1;
      e0 = errn;
      send_raw(1);
      chk(rcn == 0 && errn == e0 + 1 && lastcode == 2'd3, "R4 empty control", lastcode, 3);

      // R5 / R7 bad escape, discard to terminator, then a control message
      raw[0]=8'h01; raw[1]=8'hAA; raw[2]=8'h05; raw[3]=8'h07; raw[4]=8'h08;
      raw[5]=8'hA0; raw[6]=8'hFF; raw[7]=8'h01; raw[8]=8'hA1;
      rcn = 0; e0 = errn;
      send_raw(9);
      chk(errn == e0 + 1 && lastcode == 2'd0, "R5 escape error code", lastcode, 0);
      chk(rcn == 2 && rcap[0] == 8'hFF && rcap[1] == 8'h01 && rctrl[1] && rlast[1],
          "R7 discard then intact control message", rcn, 2);

      // R5 bad escape on a terminator resynchronises at once
      raw[0]=8'h01; raw[1]=8'h02; raw[2]=8'hAA; raw[3]=8'hA0;
      raw[4]=8'h10; raw[5]=8'h20; raw[6]=8'h30; raw[7]=8'hAA; raw[8]=8'hB0; raw[9]=8'hA0;
      rcn = 0; e0 = errn;
      send_raw(10);
      chk(errn == e0 + 1 && rcn == 3 && rcap[0] == 8'h10 && rcap[2] == 8'h30 && rlast[2],
          "R5 terminator after escape resyncs", rcn, 3);

      // R6 overflow by one byte
      for (int i = 0; i < 65; i++) raw[i] = 8'h01;
      raw[65] = 8'hA0; raw[66] = 8'h04; raw[67] = 8'hA1;
      rcn = 0; e0 = errn;
      send_raw(68);
      chk(errn == e0 + 1 && lastcode == 2'd2, "R6 overlong error", lastcode, 2);
      chk(rcn == 1 && rcap[0] == 8'h04 && rctrl[0], "R7 after overlong", rcn, 1);

      // R10 receive back-pressure
      rxm_ready = 1'b0;
      raw[0]=8'h05; raw[1]=8'h06; raw[2]=8'h07; raw[3]=8'hEE; raw[4]=8'hA0;
      rcn = 0;
      send_raw(5);
      @(negedge clk);
      chk(rxm_valid && rxm_data == 8'h05 && !rxw_ready, "R10 rx held, intake closed",
          rxm_data, 8'h05);
      repeat (3) @(negedge clk);
      chk(rxm_valid && rxm_data == 8'h05 && !rxm_last, "R10 rx stable", rxm_data, 8'h05);
      rxm_ready = 1'b1;
      repeat (10) @(posedge clk);
      chk(rcn == 3 && rcap[2] == 8'h07 && rlast[2], "R10 rx drain", rcn, 3);

      // R10 transmit back-pressure with an escaped control byte
      txw_ready = 1'b0;
      wcn = 0;
      fork
         send_tx(1'b1, 1, 8'hAA, 8'h00);
         begin
            repeat (4) @(negedge clk);
            chk(txw_valid && txw_data == 8'hAA, "R10 tx held", txw_data, 8'hAA);
            txw_ready = 1'b1;
         end
      join
      repeat (6) @(posedge clk);
      chk(wcn == 3 && wcap[0] == 8'hAA && wcap[1] == 8'hBA && wcap[2] == 8'hA1,
          "R8/R9 escaped control frame", wcn, 3);

      summary();
   end

endmodule